// File: doc/BRIEF.md
# Address window switch with verify

This block places a single address window of a host bridge onto one of several cores that share a backplane. Each core owns a fixed-size slice of the backplane address space, starting at an enumeration base. An access names a target core, a width (8, 16 or 32 bits), an offset inside the core and, for writes, data. If the window already points at that core, the access goes straight to the bus. Otherwise the block programs the window register, reads it back, recovers the core index from the value it reads and compares it with the request.

A mismatch is treated as a switch that did not take. The block waits a fixed delay of about ten microseconds, counted in clock cycles from a clock-frequency parameter, and tries again. It gives up once the attempt count passes a retry limit. The block remembers which core the window maps, and that record changes only after a confirmed switch. When a switch fails, a read returns all ones of its width and a write is dropped without reaching the bus.

Top module: `addr_window_switch`

## Requirements
- R1: Every window write carries the value `core * CORE_SIZE + ENUM_BASE` for the requested core. CORE_SIZE is a power of two.
- R2: Every window write is followed by a window read. The read-back value is turned into an index as `(value - ENUM_BASE) / CORE_SIZE`. A match with the request ends the switch successfully, so a window that accepts the first write costs exactly one write.
- R3: After a mismatch the next window write comes no sooner than `(CLK_HZ / 1_000_000) * DELAY_US` cycles after the previous one. With the one-cycle read latency at the window port, it comes at most 6 cycles later than that.
- R4: The attempt count starts at 0 and rises by one at each mismatch. The switch fails at a mismatch seen when the count is already above MAX_RETRIES, so a failing switch makes exactly MAX_RETRIES + 2 window writes. A window that ignores MAX_RETRIES + 1 writes still switches successfully on write number MAX_RETRIES + 2.
- R5: An access to the core that is currently mapped makes no window write or read and goes straight to the bus.
- R6: After reset no core is mapped, so the first access switches even when it targets core 0. The mapped-core record changes only on a successful switch. After a failed switch, the previous core is still a hit and the failed core still needs a switch.
- R7: A read whose switch fails responds with `rsp_err` = 1 and `rsp_rdata` = all ones of the access width. The size codes are 0 for 8 bits (0x000000FF), 1 for 16 bits (0x0000FFFF), and 2 or 3 for 32 bits (0xFFFFFFFF).
- R8: A write whose switch fails raises no bus request and responds with `rsp_err` = 1 and `rsp_rdata` = 0.
- R9: A successful read returns the bus data cut to the access width and zero-extended, with `rsp_err` = 0. A successful write raises exactly one bus request carrying the offset, data and size of the request, and responds with `rsp_rdata` = 0.
- R10: In reset and right after it, `req_ready` = 1 and `rsp_valid`, `cfg_wr`, `cfg_rd` and `bus_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request strobe, taken when req_ready is high |
| req_ready | output | 1 | Block idle and able to take a request |
| req_core | input | CORE_W | Target core index |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Width code: 0 = 8, 1 = 16, 2/3 = 32 bits |
| req_offset | input | log2(CORE_SIZE) | Offset inside the core |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read data, zero-extended; 0 for writes |
| rsp_err | output | 1 | Switch failed for this access |
| cfg_wr | output | 1 | Window register write strobe |
| cfg_wdata | output | 32 | Window register write value |
| cfg_rd | output | 1 | Window register read strobe |
| cfg_rvalid | input | 1 | Window read data valid |
| cfg_rdata | input | 32 | Window read data |
| bus_req | output | 1 | Core access strobe (one cycle) |
| bus_write | output | 1 | Core access direction |
| bus_size | output | 2 | Core access width code |
| bus_offset | output | log2(CORE_SIZE) | Core access offset |
| bus_wdata | output | 32 | Core write data |
| bus_ack | input | 1 | Core access done |
| bus_rdata | input | 32 | Core read data |

## Verification
The bench builds the block with CLK_HZ = 2 MHz and DELAY_US = 10, which gives a 20-cycle retry delay, and keeps MAX_RETRIES = 2, CORE_SIZE = 4096 and CORE_W = 4. With these values a whole failing switch (four writes and three delays) fits in under a hundred cycles. A window model that ignores a chosen number of writes can therefore reach both sides of the retry boundary in every width, and cores 0 and 15 exercise both ends of the index range.

// File: rtl/wsw_pkg.sv
package wsw_pkg;

  localparam int WIN_W  = 32;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    SW_IDLE,
    SW_WRITE,
    SW_READ,
    SW_WAIT,
    SW_DELAY
  } sw_state_e;

  typedef enum logic [2:0] {
    AC_IDLE,
    AC_SWITCH,
    AC_ISSUE,
    AC_WAIT,
    AC_RESP
  } ac_state_e;

  // Window value for a core: index scaled by the slice size, plus base.
  function automatic logic [WIN_W-1:0] win_addr(input logic [WIN_W-1:0] idx,
                                                input logic [WIN_W-1:0] base,
                                                input int unsigned      shift);
    return (idx << shift) + base;
  endfunction

  // Core index recovered from a window value.
  function automatic logic [WIN_W-1:0] win_index(input logic [WIN_W-1:0] val,
                                                 input logic [WIN_W-1:0] base,
                                                 input int unsigned      shift);
    logic [WIN_W-1:0] rel;
    rel = val - base;
    return rel >> shift;
  endfunction

  // All ones of the access width.
  function automatic logic [DATA_W-1:0] width_ones(input logic [1:0] size);
    case (size)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // Bus data cut to the access width.
  function automatic logic [DATA_W-1:0] width_fit(input logic [DATA_W-1:0] data,
                                                  input logic [1:0]        size);
    return data & width_ones(size);
  endfunction

endpackage

// File: rtl/wsw_delay_timer.sv
module wsw_delay_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int LEN   = (CYCLES < 1) ? 1 : CYCLES;
  localparam int CNT_W = $clog2(LEN + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= CNT_W'(LEN);
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign done = (cnt == CNT_W'(1));

  // R3: once armed, the count only runs down and never reloads on its own.
  assert_timer_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/wsw_map_cache.sv
module wsw_map_cache #(
  parameter int CORE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CORE_W-1:0] lookup_idx,
  output logic              hit,
  input  logic              upd_en,
  input  logic [CORE_W-1:0] upd_idx
);
  logic              map_vld;
  logic [CORE_W-1:0] map_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_vld <= 1'b0;
      map_idx <= '0;
    end else if (upd_en) begin
      map_vld <= 1'b1;
      map_idx <= upd_idx;
    end
  end

  assign hit = map_vld && (map_idx == lookup_idx);

  // R6: the record moves only on a confirmed switch.
  assert_map_on_success_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((map_idx != $past(map_idx)) || (map_vld != $past(map_vld))) |-> $past(upd_en));

endmodule

// File: rtl/wsw_switch_fsm.sv
module wsw_switch_fsm
  import wsw_pkg::*;
#(
  parameter int              CORE_W      = 4,
  parameter logic [WIN_W-1:0] ENUM_BASE  = 32'h1800_0000,
  parameter int              SHIFT       = 12,
  parameter int              MAX_RETRIES = 2,
  parameter int              DELAY_CYC   = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CORE_W-1:0] idx,
  output logic              done,
  output logic              ok,
  output logic              cfg_wr,
  output logic [WIN_W-1:0]  cfg_wdata,
  output logic              cfg_rd,
  input  logic              cfg_rvalid,
  input  logic [WIN_W-1:0]  cfg_rdata
);
  localparam int ATT_W = $clog2(MAX_RETRIES + 2) + 1;

  sw_state_e         st;
  logic [CORE_W-1:0] target;
  logic [ATT_W-1:0]  attempts;
  logic              match;
  logic              give_up;
  logic              tmr_start;
  logic              tmr_done;

  assign match     = win_index(cfg_rdata, ENUM_BASE, SHIFT) ==
                     {{(WIN_W-CORE_W){1'b0}}, target};
  assign give_up   = attempts > ATT_W'(MAX_RETRIES);
  assign cfg_wr    = (st == SW_WRITE);
  assign cfg_rd    = (st == SW_READ);
  assign cfg_wdata = win_addr({{(WIN_W-CORE_W){1'b0}}, target}, ENUM_BASE, SHIFT);
  assign done      = (st == SW_WAIT) && cfg_rvalid && (match || give_up);
  assign ok        = match;
  assign tmr_start = (st == SW_WAIT) && cfg_rvalid && !match && !give_up;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SW_IDLE;
      target   <= '0;
      attempts <= '0;
    end else begin
      case (st)
        SW_IDLE: if (start) begin
          target   <= idx;
          attempts <= '0;
          st       <= SW_WRITE;
        end
        SW_WRITE: st <= SW_READ;
        SW_READ:  st <= SW_WAIT;
        SW_WAIT: if (cfg_rvalid) begin
          if (match || give_up) begin
            st <= SW_IDLE;
          end else begin
            attempts <= attempts + ATT_W'(1);
            st       <= SW_DELAY;
          end
        end
        SW_DELAY: if (tmr_done) st <= SW_WRITE;
        default:  st <= SW_IDLE;
      endcase
    end
  end

  wsw_delay_timer #(.CYCLES(DELAY_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .done  (tmr_done)
  );

  // R2: each window write is followed by a read-back request.
  assert_read_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_rd);

  // R3: the delay state is held until the timer expires.
  assert_delay_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SW_DELAY && !tmr_done) |=> (st == SW_DELAY));

  // R4: the attempt count never runs past the limit plus one.
  assert_retry_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    attempts <= ATT_W'(MAX_RETRIES + 1));

endmodule

// File: rtl/addr_window_switch.sv
module addr_window_switch
  import wsw_pkg::*;
#(
  parameter int              CORE_W      = 4,
  parameter int              CORE_SIZE   = 4096,
  parameter logic [31:0]     ENUM_BASE   = 32'h1800_0000,
  parameter int              MAX_RETRIES = 2,
  parameter int              CLK_HZ      = 100_000_000,
  parameter int              DELAY_US    = 10,
  localparam int             OFF_W       = $clog2(CORE_SIZE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CORE_W-1:0] req_core,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              cfg_wr,
  output logic [31:0]       cfg_wdata,
  output logic              cfg_rd,
  input  logic              cfg_rvalid,
  input  logic [31:0]       cfg_rdata,
  output logic              bus_req,
  output logic              bus_write,
  output logic [1:0]        bus_size,
  output logic [OFF_W-1:0]  bus_offset,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata
);
  localparam int SHIFT     = OFF_W;
  localparam int DELAY_CYC = (CLK_HZ / 1_000_000) * DELAY_US;

  ac_state_e         st;
  logic [CORE_W-1:0] q_core;
  logic              q_write;
  logic [1:0]        q_size;
  logic [OFF_W-1:0]  q_offset;
  logic [31:0]       q_wdata;
  logic [31:0]       rdata_q;
  logic              err_q;

  // Named internal events
  logic accept;
  logic cache_hit;
  logic sw_start;
  logic sw_done;
  logic sw_ok;
  logic map_upd;

  assign req_ready = (st == AC_IDLE);
  assign accept    = req_valid && req_ready;
  assign sw_start  = accept && !cache_hit;
  assign map_upd   = (st == AC_SWITCH) && sw_done && sw_ok;

  wsw_map_cache #(.CORE_W(CORE_W)) u_cache (
    .clk        (clk),
    .rst_n      (rst_n),
    .lookup_idx (req_core),
    .hit        (cache_hit),
    .upd_en     (map_upd),
    .upd_idx    (q_core)
  );

  wsw_switch_fsm #(
    .CORE_W      (CORE_W),
    .ENUM_BASE   (ENUM_BASE),
    .SHIFT       (SHIFT),
    .MAX_RETRIES (MAX_RETRIES),
    .DELAY_CYC   (DELAY_CYC)
  ) u_switch (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (sw_start),
    .idx        (req_core),
    .done       (sw_done),
    .ok         (sw_ok),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rd     (cfg_rd),
    .cfg_rvalid (cfg_rvalid),
    .cfg_rdata  (cfg_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= AC_IDLE;
      q_core   <= '0;
      q_write  <= 1'b0;
      q_size   <= 2'd0;
      q_offset <= '0;
      q_wdata  <= '0;
      rdata_q  <= '0;
      err_q    <= 1'b0;
    end else begin
      case (st)
        AC_IDLE: if (accept) begin
          q_core   <= req_core;
          q_write  <= req_write;
          q_size   <= req_size;
          q_offset <= req_offset;
          q_wdata  <= req_wdata;
          err_q    <= 1'b0;
          st       <= cache_hit ? AC_ISSUE : AC_SWITCH;
        end
        AC_SWITCH: if (sw_done) begin
          if (sw_ok) begin
            st <= AC_ISSUE;
          end else begin
            err_q   <= 1'b1;
            rdata_q <= q_write ? '0 : width_ones(q_size);
            st      <= AC_RESP;
          end
        end
        AC_ISSUE: st <= AC_WAIT;
        AC_WAIT: if (bus_ack) begin
          rdata_q <= q_write ? '0 : width_fit(bus_rdata, q_size);
          st      <= AC_RESP;
        end
        AC_RESP:  st <= AC_IDLE;
        default:  st <= AC_IDLE;
      endcase
    end
  end

  assign bus_req    = (st == AC_ISSUE);
  assign bus_write  = q_write;
  assign bus_size   = q_size;
  assign bus_offset = q_offset;
  assign bus_wdata  = q_wdata;
  assign rsp_valid  = (st == AC_RESP);
  assign rsp_rdata  = rdata_q;
  assign rsp_err    = err_q;

  // R5: window traffic only happens while an access waits on a switch.
  assert_hit_no_switch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr || cfg_rd) |-> (st == AC_SWITCH));

  // R7: a failed read answers with all ones of its width.
  assert_fail_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err && !q_write) |-> (rsp_rdata == width_ones(q_size)));

  // R8: a failed access never reaches the bus.
  assert_fail_no_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !err_q);

  // R10: the response strobe lasts one cycle.
  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: tb/addr_window_switch_tb.sv
module addr_window_switch_tb;
  localparam int          CORE_W  = 4;
  localparam int          CSIZE   = 4096;
  localparam logic [31:0] BASE    = 32'h1800_0000;
  localparam int          MAXR    = 2;
  localparam int          CLKHZ   = 2_000_000;
  localparam int          DUS     = 10;
  localparam int          DLY     = (CLKHZ / 1_000_000) * DUS;
  localparam int          OFF_W   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [CORE_W-1:0] req_core = '0;
  logic              req_write = 1'b0;
  logic [1:0]        req_size = 2'd0;
  logic [OFF_W-1:0]  req_offset = '0;
  logic [31:0]       req_wdata = '0;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic              rsp_err;
  logic              cfg_wr;
  logic [31:0]       cfg_wdata;
  logic              cfg_rd;
  logic              cfg_rvalid = 1'b0;
  logic [31:0]       cfg_rdata = '0;
  logic              bus_req;
  logic              bus_write;
  logic [1:0]        bus_size;
  logic [OFF_W-1:0]  bus_offset;
  logic [31:0]       bus_wdata;
  logic              bus_ack = 1'b0;
  logic [31:0]       bus_rdata = '0;

  addr_window_switch #(
    .CORE_W(CORE_W), .CORE_SIZE(CSIZE), .ENUM_BASE(BASE),
    .MAX_RETRIES(MAXR), .CLK_HZ(CLKHZ), .DELAY_US(DUS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_core(req_core),
    .req_write(req_write), .req_size(req_size), .req_offset(req_offset),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd),
    .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata), .bus_req(bus_req),
    .bus_write(bus_write), .bus_size(bus_size), .bus_offset(bus_offset),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit good, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Window register model: ignores a chosen number of writes.
  logic [31:0] win_reg = '0;
  int          ignore_n = 0;
  always @(posedge clk) begin
    if (cfg_wr) begin
      if (ignore_n > 0) ignore_n = ignore_n - 1;
      else win_reg <= cfg_wdata;
    end
    cfg_rvalid <= cfg_rd;
    if (cfg_rd) cfg_rdata <= win_reg;
  end

  // Core bus model: read data tags the mapped core and the offset.
  always @(posedge clk) begin
    int unsigned cidx;
    cidx = (win_reg - BASE) / CSIZE;
    bus_ack <= bus_req;
    if (bus_req) bus_rdata <= {8'hA5, cidx[7:0], 4'h0, bus_offset};
  end

  typedef struct {
    int          core;
    bit          write;
    logic [31:0] rdata;
    bit          err;
    int          nwr;
    int          nbus;
    logic [1:0]  size;
    logic [11:0] off;
    logic [31:0] wdata;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_wr = 0, n_bus = 0, n_rsp = 0, cyc = 0, last_wr = 0;
  int   cur_core = 0;
  logic [11:0] cap_off;
  logic [31:0] cap_data;
  logic [1:0]  cap_size;
  bit          cap_we;

  function automatic logic [31:0] cut(input logic [31:0] d, input logic [1:0] s);
    if (s == 2'd0) return {24'd0, d[7:0]};
    if (s == 2'd1) return {16'd0, d[15:0]};
    return d;
  endfunction

  // Monitor
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (cfg_wr) begin
        chk(cfg_wdata == BASE + 32'(cur_core) * CSIZE, "R1", "window value",
            cfg_wdata, BASE + 32'(cur_core) * CSIZE);
        if (n_wr > 0)
          chk((cyc - last_wr) >= DLY && (cyc - last_wr) <= DLY + 6, "R3",
              "retry gap", cyc - last_wr, DLY);
        last_wr = cyc;
        n_wr++;
      end
      if (bus_req) begin
        n_bus++;
        cap_off = bus_offset; cap_data = bus_wdata;
        cap_size = bus_size; cap_we = bus_write;
      end
      if (rsp_valid) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          chk(0, "R9", "unexpected response", 1, 0);
        end else begin
          e = exp_q.pop_front();
          chk(n_wr == e.nwr, e.tag, "window writes", n_wr, e.nwr);
          chk(n_bus == e.nbus, e.tag, "bus requests", n_bus, e.nbus);
          chk(rsp_rdata == e.rdata, e.tag, "rdata", rsp_rdata, e.rdata);
          chk(rsp_err == e.err, e.tag, "err", rsp_err, e.err);
          if (e.write && e.nbus > 0)
            chk(cap_we && cap_off == e.off && cap_data == e.wdata && cap_size == e.size,
                "R9", "bus write fields", {cap_we, cap_size, cap_off, cap_data},
                {1'b1, e.size, e.off, e.wdata});
        end
        n_wr = 0; n_bus = 0;
        n_rsp++;
      end
    end
  end

  int issued = 0;

  // Driver: computes the expected response from the requirements.
  task automatic access(input int core, input bit wr, input logic [1:0] size,
                        input logic [11:0] off, input logic [31:0] wd,
                        input int ignore, input int nwr, input bit fail,
                        input string tag);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    e.core = core; e.write = wr; e.err = fail; e.nwr = nwr;
    e.size = size; e.off = off; e.wdata = wd; e.tag = tag;
    e.nbus = fail ? 0 : 1;
    if (wr) e.rdata = 32'd0;
    else if (fail) e.rdata = (size == 2'd0) ? 32'hFF : (size == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    else e.rdata = cut({8'hA5, 8'(core), 4'h0, off}, size);
    exp_q.push_back(e);
    ignore_n   = ignore;
    cur_core   = core;
    req_valid  = 1'b1;
    req_core   = CORE_W'(core);
    req_write  = wr;
    req_size   = size;
    req_offset = off;
    req_wdata  = wd;
    issued++;
    @(negedge clk);
    req_valid = 1'b0;
    while (n_rsp < issued) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !cfg_wr && !cfg_rd && !bus_req, "R10",
        "outputs in reset", {req_ready, rsp_valid, cfg_wr, cfg_rd, bus_req}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !cfg_wr && !cfg_rd && !bus_req, "R10",
        "outputs after reset", {req_ready, rsp_valid, cfg_wr, cfg_rd, bus_req}, 5'b10000);

    // R6: nothing mapped after reset, core 0 still switches; R2 one write
    access(0, 0, 2'd2, 12'h010, 0, 0, 1, 0, "R6");
    // R5: same core is a hit
    access(0, 0, 2'd0, 12'h0F3, 0, 0, 0, 0, "R5");
    // R3: one ignored write -> retry after the delay
    access(3, 0, 2'd1, 12'h234, 0, 1, 2, 0, "R3");
    // R9: write forwarded on a hit
    access(3, 1, 2'd2, 12'h100, 32'hDEAD_BEEF, 0, 0, 0, "R9");
    // R4: limit + 1 ignored writes still succeed on the last try
    access(7, 0, 2'd2, 12'hABC, 0, MAXR + 1, MAXR + 2, 0, "R4");
    // R4/R7: limit + 2 ignored writes fail, 16-bit all ones
    access(9, 0, 2'd1, 12'h004, 0, MAXR + 2, MAXR + 2, 1, "R7");
    // R6: record kept on failure -> core 7 is still a hit
    access(7, 0, 2'd0, 12'h0C8, 0, 0, 0, 0, "R6");
    // R8: failed write is dropped
    access(9, 1, 2'd2, 12'h020, 32'h1234_5678, MAXR + 2, MAXR + 2, 1, "R8");
    // R7: 8-bit and 32-bit failures
    access(9, 0, 2'd0, 12'h001, 0, MAXR + 2, MAXR + 2, 1, "R7");
    access(9, 0, 2'd2, 12'h002, 0, MAXR + 2, MAXR + 2, 1, "R7");
    // R6: failed core is still not mapped
    access(9, 0, 2'd3, 12'h7FF, 0, 0, 1, 0, "R6");
    // R1/R9: highest core index, 16-bit read and an 8-bit write
    access(15, 0, 2'd1, 12'hFFF, 0, 0, 1, 0, "R1");
    access(15, 1, 2'd0, 12'h033, 32'h0000_005A, 0, 0, 0, "R9");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "pending responses", exp_q.size(), 0);
    finish_run();
  end

endmodule